// File: doc/BRIEF.md
# Serial Debug Scan Front-End

This block is the serial front end of a debug port. A host drives it over the standard four-wire test access pins plus an active-low test reset. It contains the sixteen-state test access controller, a four-bit instruction register, and a set of data scan chains that the current instruction selects. Two wide chains carry register accesses: one for the port's own control registers and one for the resource side behind it. A third chain of the same width carries a cancel command.

When an access chain passes through Update-DR, the block takes the shifted word apart into a read/write flag, a two-bit register address and a 32-bit data word. It offers this request downstream on a valid/ready interface. The request stays offered, with its payload unchanged, until the consumer raises ready. Only one request is in flight at a time. The consumer reports completion with a one-cycle `rsp_valid` pulse carrying the result word. The block keeps that word and shifts it out on the next Capture-DR together with a three-bit acknowledge. That acknowledge reads WAIT for as long as a request is still pending or awaiting its response, and a host retries the scan until it reads OK. Everything runs on the test clock.

Top module: `jtag_dbg_scan`

## Requirements
- R1: A low `trst_n`, or five consecutive rising edges of `tck` with `tms` high, puts the controller in Test-Logic-Reset. Being in Test-Logic-Reset loads the identification instruction 4'b1110.
- R2: The instruction register is 4 bits wide and shifts least-significant bit first. Capture-IR loads 4'b0001, so the first four bits out are 1,0,0,0. The shifted value becomes the active instruction on Update-IR.
- R3: Instruction 4'b1110 selects a 32-bit identification chain. It captures version in [31:28], part number in [27:12], maker code in [11:1] (each a parameter) and a 1 in bit 0.
- R4: Instruction 4'b1111, and any value other than 4'b1000, 4'b1010, 4'b1011 and 4'b1110, selects a 1-bit bypass chain. This chain captures 0 and delays TDI by exactly one shift cycle.
- R5: Instructions 4'b1010 (port-control target, `req_tgt`=0) and 4'b1011 (resource target, `req_tgt`=1) select 35-bit access chains. The shifted-in word holds read/write in bit 0 (1 = read), the address in [2:1] and the data in [34:3]. On Update-DR that word is issued as a request with these fields.
- R6: On Capture-DR an access chain loads the last result word into [34:3] and an acknowledge into [2:0]. The acknowledge is 3'b010 (OK) when no request is outstanding and 3'b001 (WAIT) when one is.
- R7: An Update-DR on an access chain while a request is outstanding is discarded: no new request is issued and the outstanding one is unchanged.
- R8: `req_valid` stays high with `req_data`, `req_addr`, `req_rd` and `req_tgt` stable until a cycle with `req_ready` high. A `rsp_valid` pulse updates the result only while a response is awaited, and is ignored otherwise.
- R9: Instruction 4'b1000 selects a 35-bit cancel chain laid out as in R5. Its Update-DR with data bit 0 (chain bit 3) set raises `abort_req` for exactly one cycle and issues no request. With that bit clear it does nothing.
- R10: TDO changes only on falling edges of `tck` and is 0 outside Shift-IR and Shift-DR. TMS and TDI are sampled on rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; all state runs on it |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| tdo | output | 1 | Serial data out, updated on falling edge |
| req_valid | output | 1 | Access request offered downstream |
| req_ready | input | 1 | Downstream accepts the request this cycle |
| req_data | output | 32 | Request data word |
| req_addr | output | 2 | Register address within the selected bank |
| req_rd | output | 1 | 1 = read, 0 = write |
| req_tgt | output | 1 | 0 = port-control registers, 1 = resource side |
| rsp_valid | input | 1 | One-cycle completion pulse |
| rsp_data | input | 32 | Result word of the completed request |
| abort_req | output | 1 | One-cycle cancel pulse |

## Verification
The assertions rely on three things. `trst_n` is driven low before the first clock. The consumer never raises `rsp_valid` in the same cycle that it accepts a request. The consumer may hold `req_ready` low for as long as it likes. The bench's responder accepts requests at the falling edge ahead of the capturing rising edge and answers two cycles after acceptance. It can stall acceptance for a programmed number of cycles, which is long enough that a second scan lands inside the stall and reads WAIT. TMS and TDI change only on falling edges, and TDO is read a nanosecond later, so every bit is stable across the rising edge that uses it.

// File: rtl/dbg_scan_pkg.sv
`timescale 1ns/100ps
package dbg_scan_pkg;

  localparam int IR_W   = 4;
  localparam int ID_W   = 32;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] INS_CANCEL = 4'b1000;
  localparam logic [IR_W-1:0] INS_CTL    = 4'b1010;
  localparam logic [IR_W-1:0] INS_RES    = 4'b1011;
  localparam logic [IR_W-1:0] INS_IDENT  = 4'b1110;
  localparam logic [IR_W-1:0] INS_BYPASS = 4'b1111;

  localparam logic [2:0] ACK_OK   = 3'b010;
  localparam logic [2:0] ACK_WAIT = 3'b001;

  typedef enum logic [1:0] {CH_BYPASS, CH_IDENT, CH_ACCESS} chain_e;
  typedef enum logic [1:0] {AC_NONE, AC_CANCEL, AC_CTL, AC_RES} acc_e;

  function automatic chain_e chain_of(logic [IR_W-1:0] ins);
    case (ins)
      INS_CANCEL, INS_CTL, INS_RES: chain_of = CH_ACCESS;
      INS_IDENT:                    chain_of = CH_IDENT;
      default:                      chain_of = CH_BYPASS;
    endcase
  endfunction

  function automatic acc_e access_of(logic [IR_W-1:0] ins);
    case (ins)
      INS_CANCEL: access_of = AC_CANCEL;
      INS_CTL:    access_of = AC_CTL;
      INS_RES:    access_of = AC_RES;
      default:    access_of = AC_NONE;
    endcase
  endfunction

endpackage

// File: rtl/dbg_tap_ctrl.sv
`timescale 1ns/100ps
module dbg_tap_ctrl
  import dbg_scan_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    case (state)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
      default:   nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_TLR;
    else         state <= nxt;
  end

  // run of consecutive high TMS samples, saturating at five
  logic [2:0] tms_run;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)           tms_run <= '0;
    else if (!tms)         tms_run <= '0;
    else if (tms_run != 5) tms_run <= tms_run + 3'd1;
  end

  p_five_ones_reset_r1: assert property (@(posedge tck) disable iff (!trst_n)
    (tms_run == 3'd5) |-> (state == ST_TLR));

  p_tlr_holds_r1: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_TLR && tms) |=> (state == ST_TLR));

endmodule

// File: rtl/dbg_ir.sv
`timescale 1ns/100ps
module dbg_ir
  import dbg_scan_pkg::*;
#(
  parameter int W = IR_W
)(
  input  logic         tck,
  input  logic         trst_n,
  input  tap_state_e   state,
  input  logic         tdi,
  output logic [W-1:0] ins,
  output logic         ir_lsb
);

  localparam logic [W-1:0] CAP_PAT = {{(W-2){1'b0}}, 2'b01};

  logic [W-1:0] sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr  <= '0;
      ins <= INS_IDENT;
    end else begin
      case (state)
        ST_TLR:    ins <= INS_IDENT;
        ST_CAP_IR: sr  <= CAP_PAT;
        ST_SH_IR:  sr  <= {tdi, sr[W-1:1]};
        ST_UPD_IR: ins <= sr;
        default: ;
      endcase
    end
  end

  assign ir_lsb = sr[0];

  p_tlr_ident_r1: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_TLR) |=> (ins == INS_IDENT));

  p_ir_capture_r2: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_IR) |=> (ir_lsb == 1'b1));

  p_ins_stable_r2: assert property (@(posedge tck) disable iff (!trst_n)
    (state != ST_UPD_IR && state != ST_TLR) |=> $stable(ins));

endmodule

// File: rtl/dbg_dr_chains.sv
`timescale 1ns/100ps
module dbg_dr_chains
  import dbg_scan_pkg::*;
#(
  parameter int          DW        = DATA_W,
  parameter int          AW        = ADDR_W,
  parameter logic [3:0]  ID_VER    = 4'h1,
  parameter logic [15:0] ID_PART   = 16'h4D21,
  parameter logic [10:0] ID_MAKER  = 11'h135
)(
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  input  logic [IR_W-1:0] ins,
  input  logic [DW-1:0]   result,
  input  logic            busy,
  output logic            dr_lsb,
  output logic            upd_fire,
  output logic [DW-1:0]   upd_data,
  output logic [AW-1:0]   upd_addr,
  output logic            upd_rd,
  output logic            upd_tgt,
  output logic            abort_req
);

  localparam int HDR_W = 1 + AW;          // read flag plus address, also ack width
  localparam int DR_W  = DW + HDR_W;
  localparam logic [ID_W-1:0] ID_WORD = {ID_VER, ID_PART, ID_MAKER, 1'b1};

  chain_e     kind;
  acc_e       acc;
  logic [DR_W-1:0] sr;
  logic [HDR_W-1:0] ack;

  assign kind = chain_of(ins);
  assign acc  = access_of(ins);
  assign ack  = busy ? HDR_W'(ACK_WAIT) : HDR_W'(ACK_OK);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr <= '0;
    end else if (state == ST_CAP_DR) begin
      case (kind)
        CH_ACCESS: sr <= {result, ack};
        CH_IDENT:  sr <= DR_W'(ID_WORD);
        default:   sr <= '0;
      endcase
    end else if (state == ST_SH_DR) begin
      case (kind)
        CH_ACCESS: sr <= {tdi, sr[DR_W-1:1]};
        CH_IDENT:  sr[ID_W-1:0] <= {tdi, sr[ID_W-1:1]};
        default:   sr[0] <= tdi;
      endcase
    end
  end

  assign dr_lsb   = sr[0];
  assign upd_fire = (state == ST_UPD_DR) && (acc == AC_CTL || acc == AC_RES);
  assign upd_tgt  = (acc == AC_RES);
  assign upd_rd   = sr[0];
  assign upd_addr = sr[AW:1];
  assign upd_data = sr[DR_W-1:HDR_W];

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) abort_req <= 1'b0;
    else         abort_req <= (state == ST_UPD_DR) && (acc == AC_CANCEL) && sr[HDR_W];
  end

  p_ack_legal_r6: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_DR && kind == CH_ACCESS)
      |=> (sr[2:0] == ACK_OK || sr[2:0] == ACK_WAIT));

  p_bypass_zero_r4: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_DR && kind == CH_BYPASS) |=> (dr_lsb == 1'b0));

  p_abort_single_r9: assert property (@(posedge tck) disable iff (!trst_n)
    abort_req |=> !abort_req);

  p_abort_no_req_r9: assert property (@(posedge tck) disable iff (!trst_n)
    abort_req |-> !upd_fire);

endmodule

// File: rtl/dbg_req_port.sv
`timescale 1ns/100ps
module dbg_req_port
  import dbg_scan_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
)(
  input  logic          tck,
  input  logic          trst_n,
  input  logic          upd_fire,
  input  logic [DW-1:0] upd_data,
  input  logic [AW-1:0] upd_addr,
  input  logic          upd_rd,
  input  logic          upd_tgt,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [DW-1:0] req_data,
  output logic [AW-1:0] req_addr,
  output logic          req_rd,
  output logic          req_tgt,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          busy,
  output logic [DW-1:0] result
);

  logic pend, await_rsp;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      pend      <= 1'b0;
      await_rsp <= 1'b0;
      req_data  <= '0;
      req_addr  <= '0;
      req_rd    <= 1'b0;
      req_tgt   <= 1'b0;
      result    <= '0;
    end else begin
      if (pend && req_ready) begin
        pend      <= 1'b0;
        await_rsp <= 1'b1;
      end
      if (await_rsp && rsp_valid) begin
        await_rsp <= 1'b0;
        result    <= rsp_data;
      end
      if (upd_fire && !busy) begin
        pend     <= 1'b1;
        req_data <= upd_data;
        req_addr <= upd_addr;
        req_rd   <= upd_rd;
        req_tgt  <= upd_tgt;
      end
    end
  end

  assign req_valid = pend;
  assign busy      = pend | await_rsp;

  p_hold_r8: assert property (@(posedge tck) disable iff (!trst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_data)
      && $stable(req_addr) && $stable(req_rd) && $stable(req_tgt)));

  p_single_flight_r8: assert property (@(posedge tck) disable iff (!trst_n)
    req_valid |-> !await_rsp);

  p_drop_busy_r7: assert property (@(posedge tck) disable iff (!trst_n)
    (upd_fire && busy) |=> ($stable(req_data) && $stable(req_addr) && $stable(req_tgt)));

  p_stray_rsp_r8: assert property (@(posedge tck) disable iff (!trst_n)
    (!await_rsp) |=> $stable(result));

endmodule

// File: rtl/jtag_dbg_scan.sv
`timescale 1ns/100ps
module jtag_dbg_scan
  import dbg_scan_pkg::*;
#(
  parameter logic [3:0]  ID_VER   = 4'h1,
  parameter logic [15:0] ID_PART  = 16'h4D21,
  parameter logic [10:0] ID_MAKER = 11'h135
)(
  input  logic        tck,
  input  logic        trst_n,
  input  logic        tms,
  input  logic        tdi,
  output logic        tdo,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [31:0] req_data,
  output logic [1:0]  req_addr,
  output logic        req_rd,
  output logic        req_tgt,
  input  logic        rsp_valid,
  input  logic [31:0] rsp_data,
  output logic        abort_req
);

  tap_state_e        state;
  logic [IR_W-1:0]   ins;
  logic              ir_lsb, dr_lsb;
  logic              upd_fire, upd_rd, upd_tgt, busy;
  logic [DATA_W-1:0] upd_data, result;
  logic [ADDR_W-1:0] upd_addr;

  dbg_tap_ctrl u_tap (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state(state)
  );

  dbg_ir #(.W(IR_W)) u_ir (
    .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
    .ins(ins), .ir_lsb(ir_lsb)
  );

  dbg_dr_chains #(
    .DW(DATA_W), .AW(ADDR_W),
    .ID_VER(ID_VER), .ID_PART(ID_PART), .ID_MAKER(ID_MAKER)
  ) u_dr (
    .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi), .ins(ins),
    .result(result), .busy(busy), .dr_lsb(dr_lsb),
    .upd_fire(upd_fire), .upd_data(upd_data), .upd_addr(upd_addr),
    .upd_rd(upd_rd), .upd_tgt(upd_tgt), .abort_req(abort_req)
  );

  dbg_req_port #(.DW(DATA_W), .AW(ADDR_W)) u_req (
    .tck(tck), .trst_n(trst_n),
    .upd_fire(upd_fire), .upd_data(upd_data), .upd_addr(upd_addr),
    .upd_rd(upd_rd), .upd_tgt(upd_tgt),
    .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
    .req_addr(req_addr), .req_rd(req_rd), .req_tgt(req_tgt),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .busy(busy), .result(result)
  );

  // serial output launched on the falling edge
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)                tdo <= 1'b0;
    else if (state == ST_SH_IR) tdo <= ir_lsb;
    else if (state == ST_SH_DR) tdo <= dr_lsb;
    else                        tdo <= 1'b0;
  end

  p_tdo_quiet_r10: assert property (@(posedge tck) disable iff (!trst_n)
    (state != ST_SH_IR && state != ST_SH_DR) |-> (tdo == 1'b0));

endmodule

// File: tb/test_jtag_dbg_scan.sv
`timescale 1ns/100ps
module test_jtag_dbg_scan;

  localparam logic [3:0]  V = 4'h2;
  localparam logic [15:0] P = 16'h7C31;
  localparam logic [10:0] M = 11'h2A5;
  localparam logic [31:0] ID_EXP = {V, P, M, 1'b1};

  logic tck = 0, trst_n = 0, tms = 1, tdi = 0;
  logic tdo, req_valid, req_rd, req_tgt, abort_req;
  logic req_ready = 0, rsp_valid = 0;
  logic [31:0] req_data, rsp_data = 0;
  logic [1:0]  req_addr;

  jtag_dbg_scan #(.ID_VER(V), .ID_PART(P), .ID_MAKER(M)) i_jtag_dbg_scan (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
    .req_addr(req_addr), .req_rd(req_rd), .req_tgt(req_tgt),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .abort_req(abort_req)
  );

  always #2.5 tck = ~tck;

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural downstream model ----------------
  logic [31:0] ctl_mem [4];
  logic [31:0] res_mem [4];
  int stall_left = 0, rsp_cnt = 0, n_req = 0, abort_cnt = 0, hold_err = 0;
  logic [31:0] rsp_word = 0;
  bit stray = 0, held = 0;
  logic [35:0] held_pay;
  logic [31:0] last_data;
  logic [1:0]  last_addr;
  logic        last_rd, last_tgt;

  initial for (int k = 0; k < 4; k++) begin ctl_mem[k] = 0; res_mem[k] = 0; end

  always @(negedge tck) begin
    rsp_valid = 0;
    if (stray) begin
      rsp_valid = 1; rsp_data = 32'hDEADBEEF; stray = 0;
    end else if (rsp_cnt > 0) begin
      rsp_cnt--;
      if (rsp_cnt == 0) begin rsp_valid = 1; rsp_data = rsp_word; end
    end
    if (abort_req) abort_cnt++;
    if (stall_left > 0) begin
      req_ready = 0;
      if (req_valid) stall_left--;
    end else req_ready = 1;
    if (req_valid && !req_ready) begin
      if (held && held_pay !== {req_data, req_addr, req_rd, req_tgt}) hold_err++;
      held = 1; held_pay = {req_data, req_addr, req_rd, req_tgt};
    end else held = 0;
    if (req_valid && req_ready) begin
      n_req++;
      last_data = req_data; last_addr = req_addr; last_rd = req_rd; last_tgt = req_tgt;
      if (req_rd) rsp_word = req_tgt ? res_mem[req_addr] : ctl_mem[req_addr];
      else begin
        if (req_tgt) res_mem[req_addr] = req_data; else ctl_mem[req_addr] = req_data;
        rsp_word = 0;
      end
      rsp_cnt = 2;
    end
  end

  // ---------------- pin-level host tasks ----------------
  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck);
    tms = m; tdi = d;
    #1 o = tdo;
  endtask

  task automatic idle(input int n);
    logic o;
    for (int k = 0; k < n; k++) step(0, 0, o);
  endtask

  task automatic shift_ir(input logic [3:0] code, output logic [3:0] cap);
    logic o;
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int k = 0; k < 4; k++) begin step(k == 3, code[k], o); cap[k] = o; end
    step(1, 0, o); step(0, 0, o);
  endtask

  task automatic shift_dr(input int len, input logic [34:0] din, output logic [34:0] dout);
    logic o;
    dout = '0;
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int k = 0; k < len; k++) begin step(k == len - 1, din[k], o); dout[k] = o; end
    step(1, 0, o); step(0, 0, o);
  endtask

  task automatic acc_scan(input logic [31:0] d, input logic [1:0] a, input logic rd,
                          output logic [31:0] q, output logic [2:0] ack);
    logic [34:0] dout;
    shift_dr(35, {d, a, rd}, dout);
    q = dout[34:3]; ack = dout[2:0];
  endtask

  initial begin
    repeat (20000) @(posedge tck);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic o;
    logic [3:0]  cap;
    logic [34:0] dout;
    logic [31:0] q;
    logic [2:0]  ack;
    int n0, a0;

    repeat (3) @(negedge tck);
    #1 check("R1 reset outputs", {tdo, req_valid, abort_req}, 0);
    trst_n = 1;
    step(0, 0, o);
    step(0, 0, o); check("R10 tdo idle", o, 0);

    // identification selected out of reset
    shift_dr(32, '0, dout); check("R3 ident after reset", dout[31:0], ID_EXP);

    // bypass and capture pattern
    shift_ir(4'b1111, cap); check("R2 ir capture", cap, 4'b0001);
    shift_dr(8, 35'hA5, dout); check("R4 bypass delay", dout[7:0], 8'h4A);
    shift_ir(4'b0011, cap);
    shift_dr(8, 35'h3C, dout); check("R4 unlisted as bypass", dout[7:0], 8'h78);

    // five TMS-high edges
    shift_ir(4'b1111, cap);
    for (int k = 0; k < 5; k++) step(1, 0, o);
    step(0, 0, o);
    shift_dr(32, '0, dout); check("R1 tms reset ident", dout[31:0], ID_EXP);

    // asynchronous reset mid-session
    shift_ir(4'b1111, cap);
    @(negedge tck); trst_n = 0; @(negedge tck); trst_n = 1;
    step(0, 0, o);
    shift_dr(32, '0, dout); check("R1 trst ident", dout[31:0], ID_EXP);

    // port-control write then read
    shift_ir(4'b1010, cap);
    acc_scan(32'h12345678, 2'd1, 0, q, ack);
    check("R6 idle ack ok", ack, 3'b010);
    idle(10);
    check("R5 ctl write fields", {last_data, last_addr, last_rd, last_tgt}, {32'h12345678, 2'd1, 1'b0, 1'b0});
    acc_scan(0, 2'd1, 1, q, ack);
    idle(10);
    acc_scan(0, 2'd0, 1, q, ack);
    check("R6 read result", {q, ack}, {32'h12345678, 3'b010});

    // stalled resource access
    shift_ir(4'b1011, cap);
    idle(10);
    n0 = n_req;
    stall_left = 200;
    acc_scan(32'hCAFEF00D, 2'd2, 0, q, ack);
    acc_scan(32'h0BAD0BAD, 2'd2, 0, q, ack);
    check("R6 wait while stalled", ack, 3'b001);
    idle(260);
    check("R7 busy update dropped", n_req, n0 + 1);
    check("R8 hold while not ready", hold_err, 0);
    acc_scan(0, 2'd2, 1, q, ack);
    check("R6 ok after stall", ack, 3'b010);
    idle(10);
    acc_scan(0, 2'd3, 1, q, ack);
    check("R7 value kept", q, 32'hCAFEF00D);
    idle(10);
    check("R5 res target fields", {last_addr, last_rd, last_tgt}, {2'd3, 1'b1, 1'b1});

    // stray response ignored
    stray = 1;
    idle(5);
    acc_scan(0, 2'd0, 1, q, ack);
    check("R8 stray response ignored", q, 32'h0);
    idle(10);

    // cancel chain
    shift_ir(4'b1000, cap);
    a0 = abort_cnt; n0 = n_req;
    acc_scan(32'h1, 2'd0, 0, q, ack);
    idle(3);
    check("R9 cancel pulse", {abort_cnt - a0, n_req - n0}, {32'd1, 32'd0});
    acc_scan(32'hFFFFFFFE, 2'd0, 0, q, ack);
    idle(3);
    check("R9 cancel bit clear", abort_cnt - a0, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule